// File: doc/BRIEF.md
# Sensor power and streaming state controller

This block sequences an image sensor through three operating states: hardware standby (the low-power state entered at power-up), software standby, and streaming. It leaves hardware standby only once two separate release conditions have both happened: the external active-low reset pin has been released, and the internal power-on-reset timer has expired. Either can come last. The reset pin may also be tied inactive, and then the timer alone releases the block.

From software standby, the block starts streaming when a run request arrives. A select input picks where that request comes from: a standby pin or a mode register bit. On entry to streaming the PLL is enabled. A lock counter, clocked by the external clock, then holds the ready flag low for a fixed number of cycles (6,750 by default). The stream-enable output, which gates frame generation, follows the ready flag. Once frames are running, a request to stop waits for an end-of-frame pulse so that no frame is cut short. Asserting the reset pin or the soft-reset bit sends the block back to hardware standby.

Top module: `sensor_pwr_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released with the reset pin held low, `state_o` reads hardware standby and `pll_en_o`, `ready_o` and `stream_en_o` are all low.
- R2: Hardware standby moves to software standby on the clock edge at which the reset pin is high and a power-on-reset timeout pulse is present or has been seen before (the timeout is remembered until `rst_ni`). With only one of the two conditions met, the state stays in hardware standby, and hardware standby never goes straight to streaming.
- R3: A low level on `hw_rst_pin_ni` sends the block to hardware standby at the next clock edge from any state and clears the lock counter, so that a later streaming entry waits the full lock delay again.
- R4: A high level on `soft_rst_i` sends the block to hardware standby at the next clock edge. When the bit drops and the release conditions still hold, the block returns to software standby one edge later.
- R5: When `run_src_pin_i` is 1, the run request is the inverse of `standby_pin_i` and `mode_sel_i` is ignored. When `run_src_pin_i` is 0, the run request is `mode_sel_i` and `standby_pin_i` is ignored.
- R6: Software standby moves to streaming on the edge at which the run request is high. `pll_en_o` is high exactly while the state is streaming, and `ready_o` is never high without `pll_en_o`.
- R7: `ready_o` goes high at the LOCK_CYCLES-th clock edge after the edge that entered streaming, and not earlier.
- R8: `stream_en_o` goes high one clock edge after `ready_o` rises, and only after `ready_o` has been high.
- R9: While `stream_en_o` is high, a dropped run request leaves streaming only on an edge at which `frame_end_i` is high. Until then the state stays streaming.
- R10: While streaming with `stream_en_o` still low (during lock), a dropped run request returns the block to software standby at the next edge.
- R11: State codes on `state_o`: 2'b00 is hardware standby, 2'b01 is software standby, 2'b10 is streaming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | External input clock; also clocks the lock counter |
| rst_ni | input | 1 | Asynchronous power-domain reset, active low |
| hw_rst_pin_ni | input | 1 | External reset pin, active low |
| por_timeout_i | input | 1 | Pulse or level from the internal power-on-reset timer |
| soft_rst_i | input | 1 | Soft-reset register bit |
| run_src_pin_i | input | 1 | 1: the standby pin controls streaming; 0: the mode bit does |
| standby_pin_i | input | 1 | Standby pin, high requests standby |
| mode_sel_i | input | 1 | Mode-select register bit, high requests streaming |
| frame_end_i | input | 1 | End-of-frame pulse from the frame timing |
| state_o | output | 2 | Current state code |
| pll_en_o | output | 1 | PLL enable |
| ready_o | output | 1 | Lock delay elapsed |
| stream_en_o | output | 1 | Gates frame generation |

## Verification
The run-request selector is driven with a table that sets each source active while the other is idle, and each source idle while the other is active. This shows that only the selected source moves the block out of software standby. The two reset releases are applied in both orders: timer first and then pin, and pin first and then timer. A hold with only one release shows that no single event is enough. The lock delay is checked one cycle before and at its terminal count, both on the first entry and again after a reset-pin abort, which separates a cleared counter from one that resumes. Stop requests are issued both during lock and after frames have started, which shows the difference between the immediate exit and the frame-boundary exit.

// File: rtl/sensor_pwr_pkg.sv
package sensor_pwr_pkg;
  typedef enum logic [1:0] {
    PS_HW  = 2'b00,
    PS_SW  = 2'b01,
    PS_RUN = 2'b10
  } pwr_state_e;
endpackage

// File: rtl/spc_release_gate.sv
module spc_release_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_rst_pin_ni,
  input  logic por_timeout_i,
  output logic release_o
);
  logic por_seen_q;

  // timeout is sticky so either release may come last
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            por_seen_q <= 1'b0;
    else if (por_timeout_i) por_seen_q <= 1'b1;
  end

  assign release_o = hw_rst_pin_ni & (por_seen_q | por_timeout_i);
endmodule

// File: rtl/spc_run_select.sv
module spc_run_select (
  input  logic run_src_pin_i,
  input  logic standby_pin_i,
  input  logic mode_sel_i,
  output logic run_req_o
);
  always_comb begin
    if (run_src_pin_i) run_req_o = ~standby_pin_i;
    else               run_req_o = mode_sel_i;
  end
endmodule

// File: rtl/spc_lock_timer.sv
module spc_lock_timer #(
  parameter int unsigned LOCK_CYCLES = 6750
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(LOCK_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != TERM) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == TERM);
endmodule

// File: rtl/sensor_pwr_ctrl.sv
module sensor_pwr_ctrl
  import sensor_pwr_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 6750
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hw_rst_pin_ni,
  input  logic       por_timeout_i,
  input  logic       soft_rst_i,
  input  logic       run_src_pin_i,
  input  logic       standby_pin_i,
  input  logic       mode_sel_i,
  input  logic       frame_end_i,
  output logic [1:0] state_o,
  output logic       pll_en_o,
  output logic       ready_o,
  output logic       stream_en_o
);
  pwr_state_e state_q, state_d;
  logic release_w, run_req_w, lock_done_w, stream_en_q;

  spc_release_gate u_rel (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hw_rst_pin_ni (hw_rst_pin_ni),
    .por_timeout_i (por_timeout_i),
    .release_o     (release_w)
  );

  spc_run_select u_sel (
    .run_src_pin_i (run_src_pin_i),
    .standby_pin_i (standby_pin_i),
    .mode_sel_i    (mode_sel_i),
    .run_req_o     (run_req_w)
  );

  spc_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == PS_RUN),
    .done_o (lock_done_w)
  );

  always_comb begin
    state_d = state_q;
    if (!hw_rst_pin_ni || soft_rst_i) begin
      state_d = PS_HW;
    end else begin
      unique case (state_q)
        PS_HW:  if (release_w) state_d = PS_SW;
        PS_SW:  if (run_req_w) state_d = PS_RUN;
        PS_RUN: if (!run_req_w && (!stream_en_q || frame_end_i)) state_d = PS_SW;
        default: state_d = PS_HW;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= PS_HW;
      stream_en_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      stream_en_q <= lock_done_w && (state_d == PS_RUN);
    end
  end

  assign state_o     = state_q;
  assign pll_en_o    = (state_q == PS_RUN);
  assign ready_o     = lock_done_w;
  assign stream_en_o = stream_en_q;
endmodule

// File: rtl/sensor_pwr_ctrl_chk.sv
module sensor_pwr_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hw_rst_pin_ni,
  input logic       soft_rst_i,
  input logic       frame_end_i,
  input logic [1:0] state_o,
  input logic       pll_en_o,
  input logic       ready_o,
  input logic       stream_en_o
);
  // R3
  pin_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_rst_pin_ni |=> state_o == 2'b00);

  // R4
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> state_o == 2'b00);

  // R2
  no_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b00 |=> state_o != 2'b10);

  // R6
  ready_pll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> pll_en_o);

  // R8
  en_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stream_en_o) |-> $past(ready_o));

  // R9
  frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b10 && stream_en_o && !frame_end_i && hw_rst_pin_ni && !soft_rst_i)
      |=> state_o == 2'b10);
endmodule

bind sensor_pwr_ctrl sensor_pwr_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .hw_rst_pin_ni (hw_rst_pin_ni),
  .soft_rst_i    (soft_rst_i),
  .frame_end_i   (frame_end_i),
  .state_o       (state_o),
  .pll_en_o      (pll_en_o),
  .ready_o       (ready_o),
  .stream_en_o   (stream_en_o)
);

// File: tb/sensor_pwr_ctrl_test.sv
module sensor_pwr_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK = 6750;
  localparam logic [1:0] S_HW = 2'b00, S_SW = 2'b01, S_RUN = 2'b10;
  // {run_src_pin, standby_pin, mode_sel, expect_stream}
  localparam logic [3:0] VEC [6] = '{4'b0011, 4'b0111, 4'b0000,
                                     4'b1001, 4'b1110, 4'b1100};

  logic clk = 0, rst_ni = 0;
  logic hw_rst_pin_ni = 0, por_timeout_i = 0, soft_rst_i = 0;
  logic run_src_pin_i = 0, standby_pin_i = 0, mode_sel_i = 0, frame_end_i = 0;
  logic [1:0] state_o;
  logic pll_en_o, ready_o, stream_en_o;
  int total = 0, bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_pwr_ctrl #(.LOCK_CYCLES(LOCK)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .hw_rst_pin_ni(hw_rst_pin_ni),
    .por_timeout_i(por_timeout_i), .soft_rst_i(soft_rst_i),
    .run_src_pin_i(run_src_pin_i), .standby_pin_i(standby_pin_i),
    .mode_sel_i(mode_sel_i), .frame_end_i(frame_end_i), .state_o(state_o),
    .pll_en_o(pll_en_o), .ready_o(ready_o), .stream_en_o(stream_en_o));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    tick(2);
    chk("R1 state", {2'b0, state_o}, {2'b0, S_HW});
    chk("R1 outs", {1'b0, pll_en_o, ready_o, stream_en_o}, 4'h0);
    rst_ni = 1; tick(3);
    chk("R11 hw code", {2'b0, state_o}, {2'b0, S_HW});
    hw_rst_pin_ni = 1; tick(4);
    chk("R2 pin only", {2'b0, state_o}, {2'b0, S_HW});
    por_timeout_i = 1; tick(1); por_timeout_i = 0;
    chk("R2 timeout last", {2'b0, state_o}, {2'b0, S_SW});
    hw_rst_pin_ni = 0; tick(1);
    chk("R3 pin from sw", {2'b0, state_o}, {2'b0, S_HW});
    tick(2); hw_rst_pin_ni = 1; tick(1);
    chk("R2 pin last", {2'b0, state_o}, {2'b0, S_SW});

    // R5 selector table
    for (int v = 0; v < 6; v++) begin
      run_src_pin_i = VEC[v][3]; standby_pin_i = VEC[v][2]; mode_sel_i = VEC[v][1];
      tick(1);
      chk("R5 select", {2'b0, state_o}, {2'b0, VEC[v][0] ? S_RUN : S_SW});
      run_src_pin_i = 0; mode_sel_i = 0; standby_pin_i = 0;
      tick(1);
      chk("R10 early stop", {2'b0, state_o}, {2'b0, S_SW});
    end

    // R6 R7 R8 lock timing
    mode_sel_i = 1; tick(1);
    chk("R6 enter", {1'b0, state_o, pll_en_o}, {1'b0, S_RUN, 1'b1});
    tick(LOCK - 1);
    chk("R7 before term", {3'b0, ready_o}, 4'h0);
    tick(1);
    chk("R7 at term", {2'b0, ready_o, stream_en_o}, 4'b0010);
    tick(1);
    chk("R8 follows", {2'b0, ready_o, stream_en_o}, 4'b0011);

    // R9 frame boundary stop
    mode_sel_i = 0; tick(3);
    chk("R9 hold", {1'b0, state_o, stream_en_o}, {1'b0, S_RUN, 1'b1});
    frame_end_i = 1; tick(1); frame_end_i = 0;
    chk("R9 exit", {state_o, pll_en_o, stream_en_o}, {S_SW, 2'b00});

    // R10 during lock
    mode_sel_i = 1; tick(6);
    mode_sel_i = 0; tick(1);
    chk("R10 lock stop", {2'b0, state_o}, {2'b0, S_SW});

    // R3 abort then full relock
    mode_sel_i = 1; tick(LOCK + 2);
    chk("R3 pre stream", {3'b0, stream_en_o}, 4'h1);
    hw_rst_pin_ni = 0; tick(1);
    chk("R3 abort", {state_o, pll_en_o, stream_en_o}, {S_HW, 2'b00});
    hw_rst_pin_ni = 1; tick(2);
    chk("R3 reenter", {2'b0, state_o}, {2'b0, S_RUN});
    tick(LOCK - 1);
    chk("R3 counter cleared", {3'b0, ready_o}, 4'h0);
    tick(1);
    chk("R7 relock", {3'b0, ready_o}, 4'h1);

    // R4 soft reset
    soft_rst_i = 1; tick(1);
    chk("R4 soft", {1'b0, state_o, stream_en_o}, {1'b0, S_HW, 1'b0});
    soft_rst_i = 0; tick(1);
    chk("R4 return", {2'b0, state_o}, {2'b0, S_SW});
    tick(1);
    chk("R6 restart", {1'b0, state_o, pll_en_o}, {1'b0, S_RUN, 1'b1});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule